// File: doc/BRIEF.md
# Two-Class Prioritised Coherence Message Channel

This block moves coherence traffic from one endpoint to another over a single shared link. Two kinds of message use it. Responses travel in the high class and have their own input port. Requests travel in the low class and also have their own input port. On the sending side each class is written into its own queue, and an arbiter puts one message per cycle onto the link. Each message on the link carries a one-bit class tag.

On the receiving side the tag steers each arriving message into a class queue of its own. A single output presents the head message: it is the oldest response when one is waiting, and otherwise the oldest request. Requests can therefore pile up or stall anywhere along the path without holding back a response, even though both classes share the same wires. Within a class, messages come out in the order they went in. The consumer at the output is expected to take high-class messages whenever they appear, so the response class always drains.

Top module: `prio_msg_link`

## Requirements
- R1: After reset, and after any later reset, `out_valid` is 0 while `rsp_ready` and `req_ready` are both 1.
- R2: A message that enters on the response port leaves with `out_hi` = 1, and one that enters on the request port leaves with `out_hi` = 0. The data is unchanged. While a response is shown and `out_ready` is 0, the output keeps showing the same response.
- R3: Within each class, messages leave in the order in which they were accepted.
- R4: A request is presented only when the receiver holds no response. When both classes are waiting, every waiting response leaves before any request.
- R5: When the request path is completely full and the consumer is stalled, `rsp_ready` stays 1. A response accepted at that point is the next message presented.
- R6: When the channel is empty, a message accepted at clock edge k is presented at the output after edge k+1.
- R7: With `out_ready` held at 0, each class path buffers 2*DEPTH messages (DEPTH in each of its two queues). After that, its input ready drops to 0.
- R8: When a class path is full and the consumer takes a message of that class in the same cycle, that class's input ready is 1 in that cycle. The new message is accepted at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsp_valid | input | 1 | High-class (response) message offered |
| rsp_ready | output | 1 | High-class message accepted this cycle when valid |
| rsp_data | input | DATA_W | High-class message payload |
| req_valid | input | 1 | Low-class (request) message offered |
| req_ready | output | 1 | Low-class message accepted this cycle when valid |
| req_data | input | DATA_W | Low-class message payload |
| out_valid | output | 1 | A message is presented at the output |
| out_ready | input | 1 | Consumer takes the presented message |
| out_hi | output | 1 | Class of presented message: 1 response, 0 request |
| out_data | output | DATA_W | Presented message payload |

## Verification
The assertions watch several properties on every cycle:
- A request is never popped in the cycle after a response reached the receiver.
- A response held under back-pressure stays stable.
- The response input is open whenever its sending queue is empty.
- Every queue keeps its write pointer still when full, and goes empty after its last entry leaves.

Other behaviours appear only in the bench scenarios:
- End-to-end ordering within a class.
- The overtaking of queued requests by later responses.
- The exact two-edge latency.
- The 2*DEPTH buffering limit.
- Same-cycle refill of a full path.

// File: rtl/prio_link_pkg.sv
package prio_link_pkg;
  typedef enum logic {
    CLS_REQ = 1'b0,
    CLS_RSP = 1'b1
  } msg_class_e;
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o,
  output logic         space_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d, empty_q, empty_d;
  logic          pop_ok, push_ok;

  assign pop_ok  = pop_i & ~empty_q;
  assign push_ok = push_i & (~full_q | pop_ok);
  assign space_o = ~full_q | pop_ok;
  assign full_o  = full_q;
  assign empty_o = empty_q;
  assign rdata_o = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_ok) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (!push_ok && pop_ok) cnt_d = cnt_q - 1'b1;
    full_d  = (cnt_d == FULLC);
    empty_d = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata_i;
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop_ok) |=> $stable(wr_q));
  p_drain_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(1) && pop_ok && !push_ok) |=> empty_q);
  p_flags_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rx_hi_space,
  input  logic              rx_lo_space,
  output logic              link_valid,
  output logic              link_hi,
  output logic [DATA_W-1:0] link_data
);
  import prio_link_pkg::*;

  logic              hi_empty, lo_empty, hi_full, lo_full;
  logic              hi_sel, lo_sel;
  logic [DATA_W-1:0] hi_head, lo_head;

  always_comb begin
    hi_sel = ~hi_empty & rx_hi_space;
    lo_sel = ~hi_sel & ~lo_empty & rx_lo_space;
  end

  assign link_valid = hi_sel | lo_sel;
  assign link_hi    = hi_sel ? CLS_RSP : CLS_REQ;
  assign link_data  = hi_sel ? hi_head : lo_head;

  msg_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_hi_q (
    .clk(clk), .rst_n(rst_n), .push_i(rsp_valid), .wdata_i(rsp_data),
    .pop_i(hi_sel), .rdata_o(hi_head), .full_o(hi_full),
    .empty_o(hi_empty), .space_o(rsp_ready));

  msg_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_lo_q (
    .clk(clk), .rst_n(rst_n), .push_i(req_valid), .wdata_i(req_data),
    .pop_i(lo_sel), .rdata_o(lo_head), .full_o(lo_full),
    .empty_o(lo_empty), .space_o(req_ready));

  p_rsp_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_empty |-> rsp_ready);
  p_lo_path_indep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_full && !hi_full) |-> rsp_ready);
endmodule

// File: rtl/link_rx.sv
module link_rx #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_valid,
  input  logic              link_hi,
  input  logic [DATA_W-1:0] link_data,
  output logic              hi_space,
  output logic              lo_space,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hi,
  output logic [DATA_W-1:0] out_data
);
  logic              hi_push, lo_push, hi_pop, lo_pop;
  logic              hi_empty, lo_empty, hi_full, lo_full;
  logic [DATA_W-1:0] hi_head, lo_head;

  always_comb begin
    hi_push = link_valid & link_hi;
    lo_push = link_valid & ~link_hi;
    hi_pop  = out_ready & ~hi_empty;
    lo_pop  = out_ready & hi_empty & ~lo_empty;
  end

  assign out_valid = ~hi_empty | ~lo_empty;
  assign out_hi    = ~hi_empty;
  assign out_data  = hi_empty ? lo_head : hi_head;

  msg_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_hi_q (
    .clk(clk), .rst_n(rst_n), .push_i(hi_push), .wdata_i(link_data),
    .pop_i(hi_pop), .rdata_o(hi_head), .full_o(hi_full),
    .empty_o(hi_empty), .space_o(hi_space));

  msg_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_lo_q (
    .clk(clk), .rst_n(rst_n), .push_i(lo_push), .wdata_i(link_data),
    .pop_i(lo_pop), .rdata_o(lo_head), .full_o(lo_full),
    .empty_o(lo_empty), .space_o(lo_space));

  p_lo_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hi_push) |-> !lo_pop);
  p_hi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hi && !out_ready) |=> (out_valid && out_hi && $stable(out_data)));
endmodule

// File: rtl/prio_msg_link.sv
module prio_msg_link #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hi,
  output logic [DATA_W-1:0] out_data
);
  logic              lk_valid, lk_hi, rx_hi_space, rx_lo_space;
  logic [DATA_W-1:0] lk_data;

  link_tx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .rx_hi_space(rx_hi_space), .rx_lo_space(rx_lo_space),
    .link_valid(lk_valid), .link_hi(lk_hi), .link_data(lk_data));

  link_rx #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .link_valid(lk_valid), .link_hi(lk_hi), .link_data(lk_data),
    .hi_space(rx_hi_space), .lo_space(rx_lo_space),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hi(out_hi), .out_data(out_data));

  p_link_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hi ? rx_hi_space : rx_lo_space));
endmodule

// File: tb/prio_msg_link_bench.sv
module prio_msg_link_bench;
  localparam int DW = 16;
  localparam int DEPTH = 4;
  localparam int NV = 8;

  typedef struct packed { logic hi; logic [DW-1:0] d; } vec_t;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 16'h1001}, '{1'b1, 16'h2001}, '{1'b0, 16'h1002}, '{1'b0, 16'h1003},
    '{1'b1, 16'h2002}, '{1'b0, 16'h1004}, '{1'b1, 16'h2003}, '{1'b0, 16'h1005}};

  logic clk = 1'b0;
  logic rst_n;
  logic rsp_valid, req_valid, out_ready;
  logic [DW-1:0] rsp_data, req_data;
  logic rsp_ready, req_ready, out_valid, out_hi;
  logic [DW-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_msg_link #(.DATA_W(DW), .DEPTH(DEPTH)) u_prio_msg_link (
    .clk(clk), .rst_n(rst_n),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hi(out_hi), .out_data(out_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic hi, input logic [DW-1:0] d);
    @(negedge clk);
    if (hi) begin rsp_valid = 1'b1; rsp_data = d; end
    else    begin req_valid = 1'b1; req_data = d; end
    while (!(hi ? rsp_ready : req_ready)) @(negedge clk);
    @(posedge clk); #1;
    rsp_valid = 1'b0; req_valid = 1'b0;
  endtask

  task automatic get(output logic hi, output logic [DW-1:0] d);
    @(negedge clk);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    hi = out_hi; d = out_data;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic h;
    logic [DW-1:0] d;
    vec_t exp_q [NV];
    int k;
    rsp_valid = 0; req_valid = 0; out_ready = 0; rsp_data = '0; req_data = '0;
    do_reset();

    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(rsp_ready && req_ready, "R1 readies", {rsp_ready, req_ready}, 3);

    // R6 latency, R2 class and data
    put(1'b1, 16'hA1A1);
    chk(out_valid == 1'b0, "R6 not yet valid", out_valid, 0);
    @(posedge clk); #1;
    chk(out_valid && out_hi, "R6 valid after k+1", {out_valid, out_hi}, 3);
    chk(out_data == 16'hA1A1, "R2 data", out_data, 16'hA1A1);
    get(h, d);
    put(1'b0, 16'hB2B2);
    @(posedge clk); #1;
    chk(out_valid && !out_hi && out_data == 16'hB2B2, "R2 low class", {out_hi, out_data}, 16'hB2B2);
    get(h, d);

    // table walk: R3 order within class, R4 responses first
    k = 0;
    for (int i = 0; i < NV; i++) if (TBL[i].hi) begin exp_q[k] = TBL[i]; k++; end
    for (int i = 0; i < NV; i++) if (!TBL[i].hi) begin exp_q[k] = TBL[i]; k++; end
    for (int i = 0; i < NV; i++) put(TBL[i].hi, TBL[i].d);
    repeat (3) @(posedge clk);
    for (int i = 0; i < NV; i++) begin
      get(h, d);
      chk(h == exp_q[i].hi, "R4 class order", h, exp_q[i].hi);
      chk(d == exp_q[i].d, "R3 data order", d, exp_q[i].d);
    end

    // R7 low path capacity, R5 response bypass
    for (int i = 0; i < 2*DEPTH; i++) put(1'b0, 16'h3000 + 16'(i));
    @(negedge clk);
    chk(req_ready == 1'b0, "R7 low path full", req_ready, 0);
    chk(rsp_ready == 1'b1, "R5 rsp open", rsp_ready, 1);
    put(1'b1, 16'h5555);
    @(posedge clk);
    get(h, d);
    chk(h == 1'b1 && d == 16'h5555, "R5 response first", {h, d}, 17'h15555);
    for (int i = 0; i < 2*DEPTH; i++) begin
      get(h, d);
      chk(h == 1'b0 && d == 16'h3000 + 16'(i), "R3 low drain", d, 16'h3000 + i);
    end

    // R7 high path capacity, R8 full path refill
    for (int i = 0; i < 2*DEPTH; i++) put(1'b1, 16'h4000 + 16'(i));
    @(negedge clk);
    chk(rsp_ready == 1'b0, "R7 high path full", rsp_ready, 0);
    out_ready = 1'b1; rsp_valid = 1'b1; rsp_data = 16'h4008;
    #1;
    chk(rsp_ready == 1'b1, "R8 ready on pop", rsp_ready, 1);
    chk(out_hi && out_data == 16'h4000, "R8 head", out_data, 16'h4000);
    @(posedge clk); #1;
    rsp_valid = 1'b0; out_ready = 1'b0;
    for (int i = 1; i <= 2*DEPTH; i++) begin
      get(h, d);
      chk(h && d == 16'h4000 + 16'(i), "R8 refill order", d, 16'h4000 + i);
    end

    // R1 reset while loaded
    put(1'b0, 16'h6666);
    put(1'b1, 16'h7777);
    do_reset();
    chk(out_valid == 1'b0 && rsp_ready && req_ready, "R1 mid reset",
        {out_valid, rsp_ready, req_ready}, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule